// File: doc/BRIEF.md
# Write Status Readback Logic

This block chooses what a host sees on the data pins of a byte-wide nonvolatile memory when it issues a read. When no internal program cycle is running, a read returns the array byte at the addressed location. While the write controller reports busy, the read instead returns a status pattern. The host can poll this pattern to find out when programming has finished, without a dedicated ready pin.

The status pattern has three driven bits. Bit 7 holds the inverse of bit 7 of the most recently written byte. Bit 6 alternates from one completed read to the next and starts at 0 in each new program cycle. Bit 5 shows whether the page-load window has closed. Bits 4..0 are left floating.

Tri-state behaviour is modelled with a per-bit drive-enable vector next to the data vector. A read is recognised while chip enable and output enable are both low and write enable is high.

Top module: `wr_status_rdback`

## Requirements
- R1: `dq_oe` is 8'h00 whenever `ce_n` is 1, `oe_n` is 1 or `we_n` is 0.
- R2: During a read with `busy` 0, `dq_out` equals `array_data` and `dq_oe` is 8'hFF.
- R3: During a read with `busy` 1, `dq_out[7]` is the inverse of `last_data[7]`, for any address.
- R4: During `busy`, `dq_out[6]` keeps its value for the whole of one read strobe and inverts after each read strobe ends.
- R5: The first read after `busy` rises returns `dq_out[6]` = 0, whatever reads took place before.
- R6: During a read with `busy` 1, `dq_out[5]` equals `load_expired` (0 = timer running, 1 = timed out).
- R7: During a read with `busy` 1, `dq_oe` is 8'hE0, so bits 4..0 are undriven, and `dq_out[4:0]` is 0.
- R8: Once `busy` falls, a read returns true array data, and reads made while ready do not advance the bit-6 sequence.
- R9: After reset with no read strobe, no bit is driven, and the bit-6 sequence starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal program cycle in progress |
| load_expired | input | 1 | Page-load window has closed |
| last_data | input | 8 | Most recently written byte |
| array_data | input | 8 | Array byte at the current address |
| dq_out | output | 8 | Data presented on the pins |
| dq_oe | output | 8 | Per-bit drive enable for `dq_out` |

## Verification
The data bits, bit 7, bit 5 and the drive enables are combinational functions of the strobes and flags. They are due in the same cycle as the stimulus, so the bench drives inputs on a falling edge and samples on the next falling edge. Bit 6 advances only at the first rising edge after a read strobe has been released. The bench therefore lets each read close and pass one rising edge before it opens the next read and compares against its own running parity. A full sweep of all 256 values of `last_data` checks bit 7, bit 6 and bit 5 together in every busy read.

// File: rtl/wr_status_rdback.sv
module wr_status_rdback #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic         we_n,
  input  logic         busy,
  input  logic         load_expired,
  input  logic [W-1:0] last_data,
  input  logic [W-1:0] array_data,
  output logic [W-1:0] dq_out,
  output logic [W-1:0] dq_oe
);
  localparam int LOW = W - 3;

  logic rd, rd_q, tgl;

  assign rd = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      rd_q <= rd;
      if (!busy)
        tgl <= 1'b0;
      else if (rd_q && !rd)
        tgl <= ~tgl;
    end
  end

  assign dq_out = !rd  ? '0 :
                  busy ? {~last_data[W-1], tgl, load_expired, {LOW{1'b0}}} :
                         array_data;
  assign dq_oe  = !rd  ? '0 :
                  busy ? {3'b111, {LOW{1'b0}}} :
                         '1;
endmodule

// File: rtl/wr_status_rdback_chk.sv
module wr_status_rdback_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ce_n,
  input logic         oe_n,
  input logic         we_n,
  input logic         busy,
  input logic         load_expired,
  input logic [W-1:0] last_data,
  input logic [W-1:0] array_data,
  input logic [W-1:0] dq_out,
  input logic [W-1:0] dq_oe
);
  logic rd_c;
  assign rd_c = ~ce_n & ~oe_n & we_n;

  p_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_oe == '0));

  p_ready_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !busy) |-> (dq_out == array_data && dq_oe == '1));

  p_inverted_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy) |-> (dq_out[W-1] != last_data[W-1]));

  p_steady_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy && $past(rd_c) && $past(busy)) |-> $stable(dq_out[W-2]));

  p_timer_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy) |-> (dq_out[W-3] == load_expired));

  p_low_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && busy) |-> (dq_oe[W-4:0] == '0 && dq_oe[W-1:W-3] == 3'b111));
endmodule

bind wr_status_rdback wr_status_rdback_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .load_expired(load_expired), .last_data(last_data),
  .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_wr_status_rdback.sv
module tb_wr_status_rdback;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic busy = 1'b0, load_expired = 1'b0;
  logic [7:0] last_data = 8'h00, array_data = 8'h00;
  logic [7:0] dq_out, dq_oe;

  int n_chk = 0, n_bad = 0;
  int cycles = 0;
  bit finished = 0;
  logic exp_tgl;

  always #10 clk = ~clk;

  wr_status_rdback dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .load_expired(load_expired), .last_data(last_data),
    .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic open_read();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_read();
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic busy_read(input string tag);
    open_read();
    chk({tag, " R3 msb"}, {7'd0, dq_out[7]}, {7'd0, ~last_data[7]});
    chk({tag, " R4 toggle"}, {7'd0, dq_out[6]}, {7'd0, exp_tgl});
    chk({tag, " R6 timer"}, {7'd0, dq_out[5]}, {7'd0, load_expired});
    chk({tag, " R7 oe"}, dq_oe, 8'hE0);
    chk({tag, " R7 low bits"}, {3'd0, dq_out[4:0]}, 8'h00);
    @(negedge clk);
    chk({tag, " R4 steady"}, {7'd0, dq_out[6]}, {7'd0, exp_tgl});
    close_read();
    exp_tgl = ~exp_tgl;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset oe", dq_oe, 8'h00);
    chk("R9 reset out", dq_out, 8'h00);

    busy = 1'b1; exp_tgl = 1'b0;
    last_data = 8'h80;
    busy_read("R9 first after reset");

    busy = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      array_data = 8'(i * 17 + 3);
      open_read();
      chk("R2 ready data", dq_out, 8'(i * 17 + 3));
      chk("R2 ready oe", dq_oe, 8'hFF);
      close_read();
    end

    busy = 1'b1; exp_tgl = 1'b0;
    for (int i = 0; i < 256; i++) begin
      last_data = 8'(i);
      array_data = 8'(i) ^ 8'h5A;
      load_expired = i[2];
      busy_read(i == 0 ? "R5 first read" : "sweep");
    end

    ce_n = 1'b1; oe_n = 1'b0; @(negedge clk);
    chk("R1 ce high", dq_oe, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1; @(negedge clk);
    chk("R1 oe high", dq_oe, 8'h00);
    oe_n = 1'b0; we_n = 1'b0; @(negedge clk);
    chk("R1 we low", dq_oe, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; @(negedge clk);

    busy_read("R4 after hiz");

    exp_tgl = 1'b0;
    busy = 1'b0; array_data = 8'hC3; last_data = 8'h00;
    @(negedge clk);
    open_read();
    chk("R8 true data", dq_out, 8'hC3);
    chk("R8 oe", dq_oe, 8'hFF);
    close_read();
    open_read(); close_read();
    open_read(); close_read();
    busy = 1'b1; load_expired = 1'b0; last_data = 8'h7F;
    busy_read("R5 new sequence");
    busy_read("R4 second");

    busy = 1'b0; @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
    chk("R1 idle", dq_oe, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1;
    $finish;
  end
endmodule